// File: doc/BRIEF.md
# Up/Down Autoreload Timer with Extension Bit

This block is a 16-bit event timer that advances on ticks taken from the system clock through a power-of-two prescaler. A mode control decides how the count moves. With it cleared, the timer only counts upward. With it set, a direction input chooses the way: high counts up and low counts down. Counting up, the timer wraps to zero once it has passed the programmed limit. Counting down, it reloads the limit when it leaves zero. Every wrap or reload is a terminal event.

A terminal event sets a sticky overflow flag, which software clears with a write-one strobe. It also toggles an extension flag, which extends the count to 17 bits. The interrupt request is either flag, gated by an enable input.

A three-state controller tracks the run and direction inputs one clock behind them. Its states are HALT, UP and DOWN. The transitions are START (HALT to UP or DOWN when run is raised), STOP (UP or DOWN to HALT when run drops) and REVERSE (UP to DOWN or back when the effective direction changes). The prescaler phase runs only in UP or DOWN, and the state picks the counting direction.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset the count, the limit, the prescaler phase, the overflow flag, the extension flag and the interrupt are all 0.
- R2: With `dir_mode` = 0 the timer counts up by one per tick, whatever the level on `dir_pin`.
- R3: Counting up, a tick that finds the count equal to the limit, or equal to FFFFh, loads 0000h. That tick is a terminal event.
- R4: With `dir_mode` = 1 and `dir_pin` = 0 the timer counts down by one per tick. A tick that finds the count at 0000h loads the limit, and that tick is a terminal event.
- R5: The state machine moves out of HALT only while `run` = 1. Outside HALT, a tick occurs in every cycle where the low `presc_sel` bits of a free-running phase counter are all ones, which gives one tick per 2^`presc_sel` cycles. In HALT the phase is cleared to 0 and the count holds.
- R6: A terminal event sets `ovf_flag`. `ovf_clr` = 1 clears it on the next edge, but a terminal event in the same cycle wins. Otherwise the flag holds.
- R7: `ext_flag` toggles on every terminal event and on nothing else.
- R8: `irq` is high exactly when (`ovf_flag` OR `ext_flag`) AND `irq_en`. `irq` is combinational in `irq_en`.
- R9: `lim_wr` = 1 loads `lim_wdata` into the limit at the edge. The new limit is used by the compare from the next cycle on.
- R10: The `run`, `dir_mode` and `dir_pin` inputs reach the state register one edge before they affect a tick or the direction of a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run enable |
| dir_mode | input | 1 | 1: direction taken from dir_pin; 0: up only |
| dir_pin | input | 1 | Direction level, 1 up and 0 down |
| presc_sel | input | 3 | Prescaler exponent N, divide by 2^N |
| lim_wr | input | 1 | Limit write strobe |
| lim_wdata | input | 16 | Limit write data |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow/underflow flag |
| ext_flag | output | 1 | Extension flag, count bit 16 |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps prescaler settings, small limits including zero, and both directions. It also flips direction every few cycles.

- An off-by-one terminal compare would wrap one step early or late. The mistake would surface as a count that differs from the arithmetic expectation in the cycle of the event.
- A wrong down reload, for example loading FFFFh or reloading at 1, would break the sequence that follows zero.
- A limit lowered beneath the current count is exercised too. A design that missed the FFFFh rollover event would leave the extension flag stale.
- Clear strobes are held across terminal events. A clear given priority over a set would drop the overflow flag.
- Run gaps check that the prescaler phase restarts and the count freezes.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/updn_tick_gen.sv
module updn_tick_gen #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PH_W = (1 << SEL_W) - 1;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PH_W; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!active) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    assign tick = active && ((phase_q & mask) == mask);

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (phase_q == '0)); // R5
    AST_DIV1_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sel == '0) |-> tick); // R5

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          count_up,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          wrap
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic          at_top;
    logic          at_floor;
    logic [CW-1:0] count_d;

    assign at_top   = (count == limit) || (count == CNT_MAX);
    assign at_floor = (count == '0);
    assign wrap     = tick && (count_up ? at_top : at_floor);

    always_comb begin
        count_d = count;
        if (tick) begin
            if (count_up) begin
                count_d = at_top ? '0 : count + CW'(1);
            end else begin
                count_d = at_floor ? limit : count - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_d;
        end
    end

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_up && !at_top) |=> (count == $past(count) + CW'(1))); // R2
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_up && at_top) |=> (count == '0)); // R3
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !count_up && !at_floor) |=> (count == $past(count) - CW'(1))); // R4
    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !count_up && at_floor) |=> (count == $past(limit))); // R4
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R5

endmodule

// File: rtl/updn_flag_unit.sv
module updn_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ovf_clr,
    output logic ovf,
    output logic ext
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            ext <= 1'b0;
        end else begin
            if (wrap) begin
                ovf <= 1'b1;
            end else if (ovf_clr) begin
                ovf <= 1'b0;
            end
            ext <= ext ^ wrap;
        end
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf); // R6
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !wrap) |=> !ovf); // R6
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_clr && !wrap) |=> $stable(ovf)); // R6
    AST_EXT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (ext != $past(ext))); // R7
    AST_EXT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(ext)); // R7

endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
    import updn_timer_pkg::*;
#(
    parameter int CW    = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             dir_mode,
    input  logic             dir_pin,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             lim_wr,
    input  logic [CW-1:0]    lim_wdata,
    input  logic             ovf_clr,
    input  logic             irq_en,
    output logic [CW-1:0]    count,
    output logic             ovf_flag,
    output logic             ext_flag,
    output logic             irq
);
    tmr_state_e    state_q, state_d;
    logic          want_up;
    logic          presc_active;
    logic          cnt_up;
    logic          tick;
    logic          wrap;
    logic [CW-1:0] lim_q;

    assign want_up = !dir_mode || dir_pin;

    // Next-state logic: START, STOP and REVERSE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (run) state_d = want_up ? ST_UP : ST_DOWN;     // START
            end
            ST_UP: begin
                if (!run)         state_d = ST_HALT;              // STOP
                else if (!want_up) state_d = ST_DOWN;             // REVERSE
            end
            ST_DOWN: begin
                if (!run)         state_d = ST_HALT;              // STOP
                else if (want_up) state_d = ST_UP;                // REVERSE
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        presc_active = 1'b0;
        cnt_up       = 1'b1;
        unique case (state_q)
            ST_HALT: begin
                presc_active = 1'b0;
                cnt_up       = 1'b1;
            end
            ST_UP: begin
                presc_active = 1'b1;
                cnt_up       = 1'b1;
            end
            ST_DOWN: begin
                presc_active = 1'b1;
                cnt_up       = 1'b0;
            end
            default: begin
                presc_active = 1'b0;
                cnt_up       = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= '0;
        end else if (lim_wr) begin
            lim_q <= lim_wdata;
        end
    end

    updn_tick_gen #(.SEL_W(SEL_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (presc_active),
        .sel    (presc_sel),
        .tick   (tick)
    );

    updn_count_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .count_up (cnt_up),
        .limit    (lim_q),
        .count    (count),
        .wrap     (wrap)
    );

    updn_flag_unit u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .ovf_clr (ovf_clr),
        .ovf     (ovf_flag),
        .ext     (ext_flag)
    );

    assign irq = (ovf_flag || ext_flag) && irq_en;

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> $stable(count)); // R5
    AST_STOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state_q == ST_HALT)); // R10
    AST_UP_ONLY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !dir_mode) |=> (state_q == ST_UP)); // R2
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en); // R8
    AST_LIMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        lim_wr |=> (lim_q == $past(lim_wdata))); // R9

endmodule

// File: tb/updn_reload_timer_test.sv
module updn_reload_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        dir_mode = 1'b0;
    logic        dir_pin = 1'b0;
    logic [2:0]  presc_sel = 3'd0;
    logic        lim_wr = 1'b0;
    logic [15:0] lim_wdata = 16'h0;
    logic        ovf_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic [15:0] count;
    logic        ovf_flag, ext_flag, irq;

    int    vecs = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference state
    int          m_state = 0;
    logic [6:0]  m_pc = '0;
    logic [15:0] m_cnt = '0;
    logic [15:0] m_lim = '0;
    bit          m_ovf = 1'b0;
    bit          m_ext = 1'b0;

    always #4 clk = ~clk;

    updn_reload_timer uut (
        .clk(clk), .rst_n(rst_n), .run(run), .dir_mode(dir_mode),
        .dir_pin(dir_pin), .presc_sel(presc_sel), .lim_wr(lim_wr),
        .lim_wdata(lim_wdata), .ovf_clr(ovf_clr), .irq_en(irq_en),
        .count(count), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0; m_pc <= '0; m_cnt <= '0; m_lim <= '0;
            m_ovf <= 1'b0; m_ext <= 1'b0;
        end else begin
            logic [6:0] msk;
            bit tk, ev, up;
            msk = 7'((1 << presc_sel) - 1);
            tk  = (m_state != 0) && ((m_pc & msk) == msk);
            up  = (m_state == 1);
            ev  = 1'b0;
            if (tk) begin
                if (up) begin
                    if (m_cnt == m_lim || m_cnt == 16'hFFFF) begin
                        m_cnt <= 16'h0; ev = 1'b1;
                    end else m_cnt <= m_cnt + 16'd1;
                end else begin
                    if (m_cnt == 16'h0) begin
                        m_cnt <= m_lim; ev = 1'b1;
                    end else m_cnt <= m_cnt - 16'd1;
                end
            end
            m_pc    <= (m_state == 0) ? 7'd0 : m_pc + 7'd1;
            m_state <= !run ? 0 : ((!dir_mode || dir_pin) ? 1 : 2);
            if (lim_wr) m_lim <= lim_wdata;
            if (ev) m_ovf <= 1'b1;
            else if (ovf_clr) m_ovf <= 1'b0;
            m_ext <= m_ext ^ ev;
        end
    end

    task automatic compare();
        bit exp_irq;
        exp_irq = (m_ovf || m_ext) && irq_en;
        vecs++;
        if (count !== m_cnt || ovf_flag !== m_ovf || ext_flag !== m_ext || irq !== exp_irq) begin
            fails++;
            $display("FAIL %s: count=%h ovf=%b ext=%b irq=%b expected count=%h ovf=%b ext=%b irq=%b",
                     cur_req, count, ovf_flag, ext_flag, irq, m_cnt, m_ovf, m_ext, exp_irq);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic set_limit(input logic [15:0] v);
        lim_wr = 1'b1; lim_wdata = v;
        step(1);
        lim_wr = 1'b0;
    endtask

    initial begin
        // R1: reset values
        cur_req = "R1 reset state";
        step(3);
        rst_n = 1'b1;
        step(2);

        // R2: up-only mode ignores dir_pin
        cur_req = "R2 up-only, pin ignored";
        set_limit(16'd9);
        run = 1'b1;
        for (int i = 0; i < 40; i++) begin
            dir_pin = i[2];
            step(1);
        end

        // R5 / R3: prescaler sweep with small limits, run gaps
        for (int ps = 0; ps < 4; ps++) begin
            for (int lim = 0; lim < 4; lim++) begin
                cur_req = "R5 prescaler sweep / R3 up wrap";
                presc_sel = 3'(ps);
                set_limit(16'(lim));
                step(3 * (lim + 2) * (1 << ps));
                run = 1'b0;
                step(5);
                run = 1'b1;
            end
        end

        // R4: down counting with reload, several limits
        presc_sel = 3'd0;
        dir_mode  = 1'b1;
        dir_pin   = 1'b0;
        for (int lim = 0; lim < 5; lim++) begin
            cur_req = "R4 down reload";
            set_limit(16'(lim * 3));
            step(4 * (lim * 3 + 2));
        end
        presc_sel = 3'd1;
        cur_req = "R4 down reload, divided";
        step(40);

        // R10: direction reversal every few cycles
        cur_req = "R10 direction reversal";
        presc_sel = 3'd0;
        set_limit(16'd6);
        for (int i = 0; i < 60; i++) begin
            dir_pin = ((i / 7) % 2 == 0);
            step(1);
        end

        // R6: clear strobe held across terminal events
        cur_req = "R6 set beats clear";
        dir_pin = 1'b1;
        set_limit(16'd0);
        ovf_clr = 1'b1;
        step(20);
        cur_req = "R6 clear while idle";
        run = 1'b0;
        step(3);
        ovf_clr = 1'b0;
        step(3);
        run = 1'b1;
        set_limit(16'd4);
        for (int i = 0; i < 40; i++) begin
            ovf_clr = (i % 5 == 2);
            step(1);
        end
        ovf_clr = 1'b0;

        // R7 / R8: extension flag and interrupt gating
        cur_req = "R7 ext toggle / R8 irq gating";
        for (int i = 0; i < 50; i++) begin
            irq_en  = i[1];
            ovf_clr = (i % 3 == 0);
            step(1);
        end
        ovf_clr = 1'b0;

        // R9 / R3: limit below count, rollover at FFFFh
        cur_req = "R9 limit write / R3 FFFFh rollover";
        dir_pin = 1'b0;
        set_limit(16'hFFF0);
        step(30);
        dir_pin = 1'b1;
        set_limit(16'd5);
        step(40);
        cur_req = "R9 limit change mid count";
        set_limit(16'd20);
        step(10);
        set_limit(16'd2);
        step(30);

        // R5: large dividers
        cur_req = "R5 large prescaler";
        for (int ps = 4; ps < 8; ps++) begin
            presc_sel = 3'(ps);
            step(3 * (1 << ps) + 5);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual not finished, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

endmodule